// File: doc/BRIEF.md
# Two-Wire Bus Target with Clock-Register Shadow and Scratch RAM

This block is the serial-bus side of a timekeeping peripheral. A bus master addresses it over a two-wire (I2C-style, standard-mode) link. Through the link the master reaches a 64-byte register space. The low eight locations belong to a time-of-day counter that lives outside this block. The remaining 56 locations form a byte-wide scratch RAM held inside it. SCL and SDA arrive already synchronised to a fast system clock. SDA is driven open-drain: the block raises `sda_oe` to pull the line low.

A write transfer begins with the address byte. The byte that follows loads an internal register pointer, and each later byte lands at that pointer, which then steps forward. A read transfer streams bytes from the pointer onward. The pointer wraps from the top of the space back to location zero. Every START, including a repeated START, freezes a copy of the time inputs, so a multi-byte read returns one consistent instant while the counter keeps running. Writes to the time locations are passed straight to the counter through a one-cycle strobe. A power-fail input cuts off any transfer in progress and clears the pointer.

The FSM uses these states:
- `ST_IDLE`: waiting for START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_PTR`: shifting in the pointer byte.
- `ST_PTR_ACK`: acknowledging the pointer byte.
- `ST_WDATA`: shifting in a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte.
- `ST_RDATA`: shifting a byte out.
- `ST_RACK`: sampling the master's acknowledge.
- `ST_IGNORE`: deaf until the next START or STOP.

The FSM moves between states as follows:
- START goes to `ST_ADDR` from any state.
- STOP goes to `ST_IDLE` from any state.
- Power-fail goes to `ST_IDLE` from any state.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_RDATA` for a read and to `ST_PTR` for a write.
- `ST_PTR` goes to `ST_PTR_ACK`, then on to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK`.
- `ST_RACK` goes back to `ST_RDATA` when the master acknowledges, and to `ST_IGNORE` when it does not.

All transitions out of a byte or acknowledge slot happen on a falling SCL edge.

Top module: `rtcb_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1101000, in either direction, by pulling SDA low for the ninth clock. Any other address draws no SDA drive at all until the next START or STOP.
- R2: START (SDA falling while SCL is high) begins a new address phase from any state, including mid-transfer (repeated START). STOP (SDA rising while SCL is high) returns the block to idle.
- R3: The block changes its SDA drive only while SCL is low. Bytes travel most significant bit first.
- R4: In a write transfer, the first byte after the address loads the pointer from its low six bits, and the upper two bits are ignored. Each following byte is stored at the pointer, the pointer increments, and every byte is acknowledged.
- R5: A read transfer starts at the current pointer and advances one location per byte. A read with no pointer written first continues from the retained pointer. A master NACK ends the transmission, and SDA stays released until the next START.
- R6: The pointer wraps from location 63 to location 0, both in write bursts and in read bursts.
- R7: A write to locations 0–7 produces a one-cycle `tm_wr_en` strobe with `tm_wr_idx` equal to the location and `tm_wr_data` equal to the byte, and it leaves the frozen copy unchanged. A write to locations 8–63 goes to the scratch RAM and produces no strobe. Both outputs are 0 after reset.
- R8: Each START copies `time_live` (location k occupies bits 8k+7..8k) into the frozen copy, and reads of locations 0–7 return that copy.
- R9: While `pwr_fail` is high, the block aborts any transfer, releases SDA, clears the pointer to 0, commits no write and recognises no START. This holds even if `pwr_fail` rises in the very cycle a data byte would commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| pwr_fail | input | 1 | Supply-fail indication, aborts bus activity |
| time_live | input | 64 | Current time-register bytes, location k at bits 8k+7..8k |
| tm_wr_en | output | 1 | One-cycle write strobe to the time counter |
| tm_wr_idx | output | 3 | Time location being written |
| tm_wr_data | output | 8 | Byte written to the time location |

## Verification
The coincidence that matters most is a data byte committing at the same system-clock edge on which the power-fail input rises. The bench provokes it by raising `pwr_fail` at the very negative clock edge where the master pulls SCL low after the eighth data bit, so that both are sampled at one edge. The outcome is judged at the ports. No acknowledge may follow, and no time strobe may appear for a time location. A later read of the affected RAM location must return its earlier contents. The pointer, cleared by the abort, is observed through a read issued without a pointer write.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/rtcb_line_events.sv
module rtcb_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Line conditions are judged against the previous sample.
    assign start_ev = scl_q & scl_in & sda_q & ~sda_in;
    assign stop_ev  = scl_q & scl_in & ~sda_q & sda_in;
    assign scl_rise = ~scl_q & scl_in;
    assign scl_fall = scl_q & ~scl_in;

endmodule

// File: rtl/rtcb_time_shadow.sv
module rtcb_time_shadow #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic [N*8-1:0] live,
    input  logic [IW-1:0]  rd_idx,
    output logic [7:0]     rd_data
);

    logic [7:0] snap [N];

    for (genvar g = 0; g < N; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                snap[g] <= '0;
            end else if (capture) begin
                snap[g] <= live[g*8 +: 8];
            end
        end
    end

    assign rd_data = snap[rd_idx];

endmodule

// File: rtl/rtcb_scratch_ram.sv
module rtcb_scratch_ram #(
    parameter int DEPTH = 56,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;

endmodule

// File: rtl/rtcb_target.sv
module rtcb_target
    import rtcb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         SPACE_DEPTH = 64,
    parameter int         TIME_REGS   = 8,
    localparam int        IDX_W       = $clog2(TIME_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    input  logic                   pwr_fail,
    input  logic [TIME_REGS*8-1:0] time_live,
    output logic                   tm_wr_en,
    output logic [IDX_W-1:0]       tm_wr_idx,
    output logic [7:0]             tm_wr_data
);

    localparam int PTR_W     = $clog2(SPACE_DEPTH);
    localparam int RAM_DEPTH = SPACE_DEPTH - TIME_REGS;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);
    localparam logic [PTR_W-1:0] TIME_TOP = PTR_W'(TIME_REGS);

    // Line events
    logic start_ev, stop_ev, scl_rise, scl_fall;

    rtcb_line_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    // Registers
    tgt_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [7:0]       shift_q;
    logic [7:0]       tx_q;
    logic             rw_q;
    logic             mack_q;
    logic [PTR_W-1:0] ptr_q;
    logic             tm_wr_en_q;
    logic [IDX_W-1:0] tm_wr_idx_q;
    logic [7:0]       tm_wr_data_q;

    logic byte_done;
    logic in_time;
    logic wr_fire;
    logic snap_take;
    logic [7:0] shadow_rd, ram_rd, rd_byte;
    logic [PTR_W-1:0] ram_addr;

    assign byte_done = (bit_cnt_q == FULL_CNT);
    assign in_time   = (ptr_q < TIME_TOP);
    assign wr_fire   = (state_q == ST_WDATA) && scl_fall && byte_done && !pwr_fail;
    assign snap_take = start_ev && !pwr_fail;
    assign ram_addr  = ptr_q - TIME_TOP;

    // Frozen time copy and scratch storage
    rtcb_time_shadow #(
        .N  (TIME_REGS),
        .IW (IDX_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (snap_take),
        .live    (time_live),
        .rd_idx  (ptr_q[IDX_W-1:0]),
        .rd_data (shadow_rd)
    );

    rtcb_scratch_ram #(
        .DEPTH (RAM_DEPTH),
        .AW    (PTR_W)
    ) u_ram (
        .clk   (clk),
        .we    (wr_fire && !in_time),
        .waddr (ram_addr),
        .wdata (shift_q),
        .raddr (ram_addr),
        .rdata (ram_rd)
    );

    assign rd_byte = in_time ? shadow_rd : ram_rd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (pwr_fail) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: begin
                    state_d = state_q;
                end
                ST_ADDR: begin
                    if (scl_fall && byte_done) begin
                        state_d = (shift_q[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_d = rw_q ? ST_RDATA : ST_PTR;
                end
                ST_PTR: begin
                    if (scl_fall && byte_done) state_d = ST_PTR_ACK;
                end
                ST_PTR_ACK: begin
                    if (scl_fall) state_d = ST_WDATA;
                end
                ST_WDATA: begin
                    if (scl_fall && byte_done) state_d = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_d = ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_fall && byte_done) state_d = ST_RACK;
                end
                ST_RACK: begin
                    if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // Datapath: bit counting, shifting, pointer and time strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q    <= '0;
            shift_q      <= '0;
            tx_q         <= '0;
            rw_q         <= 1'b0;
            mack_q       <= 1'b0;
            ptr_q        <= '0;
            tm_wr_en_q   <= 1'b0;
            tm_wr_idx_q  <= '0;
            tm_wr_data_q <= '0;
        end else begin
            tm_wr_en_q <= 1'b0;
            if (pwr_fail) begin
                ptr_q     <= '0;
                bit_cnt_q <= '0;
            end else if (start_ev) begin
                bit_cnt_q <= '0;
            end else begin
                if (scl_rise) begin
                    unique case (state_q)
                        ST_ADDR, ST_PTR, ST_WDATA: begin
                            shift_q   <= {shift_q[6:0], sda_in};
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                        ST_RDATA: begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                        ST_RACK: begin
                            mack_q <= ~sda_in;
                        end
                        default: begin
                        end
                    endcase
                end
                if (scl_fall) begin
                    unique case (state_q)
                        ST_ADDR: begin
                            if (byte_done) begin
                                rw_q      <= shift_q[0];
                                bit_cnt_q <= '0;
                            end
                        end
                        ST_ADDR_ACK: begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                tx_q  <= rd_byte;
                                ptr_q <= ptr_q + PTR_W'(1);
                            end
                        end
                        ST_PTR: begin
                            if (byte_done) begin
                                ptr_q     <= shift_q[PTR_W-1:0];
                                bit_cnt_q <= '0;
                            end
                        end
                        ST_WDATA: begin
                            if (byte_done) begin
                                ptr_q     <= ptr_q + PTR_W'(1);
                                bit_cnt_q <= '0;
                                if (in_time) begin
                                    tm_wr_en_q   <= 1'b1;
                                    tm_wr_idx_q  <= ptr_q[IDX_W-1:0];
                                    tm_wr_data_q <= shift_q;
                                end
                            end
                        end
                        ST_RDATA: begin
                            if (byte_done) begin
                                bit_cnt_q <= '0;
                            end else begin
                                tx_q <= {tx_q[6:0], 1'b0};
                            end
                        end
                        ST_RACK: begin
                            bit_cnt_q <= '0;
                            if (mack_q) begin
                                tx_q  <= rd_byte;
                                ptr_q <= ptr_q + PTR_W'(1);
                            end
                        end
                        default: begin
                        end
                    endcase
                end
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx_q[7];
            default:                               sda_oe = 1'b0;
        endcase
        tm_wr_en   = tm_wr_en_q;
        tm_wr_idx  = tm_wr_idx_q;
        tm_wr_data = tm_wr_data_q;
    end

endmodule

// File: rtl/rtcb_target_checker.sv
module rtcb_target_checker #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             pwr_fail,
    input logic             sda_oe,
    input logic             tm_wr_en,
    input logic [PTR_W-1:0] ptr
);

    // R3: drive is steady across an SCL high phase
    a_r3_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && !$past(pwr_fail)) |-> $stable(sda_oe));

    // R9: power fail releases the line
    a_r9_pf_release: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !sda_oe);

    // R9: power fail clears the pointer
    a_r9_pf_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (ptr == '0));

    // R9: power fail blocks time writes
    a_r9_pf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !tm_wr_en);

    // R7: time strobes only follow a falling SCL, never while it is high
    a_r7_strobe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        tm_wr_en |-> !scl_in);

endmodule

bind rtcb_target rtcb_target_checker #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .pwr_fail (pwr_fail),
    .sda_oe   (sda_oe),
    .tm_wr_en (tm_wr_en),
    .ptr      (ptr_q)
);

// File: tb/rtcb_target_test.sv
`timescale 1ns/1ps
module rtcb_target_test;

    localparam int Q = 4;
    localparam logic [63:0] TL_A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] TL_B = 64'hF0E1_D2C3_B4A5_9687;
    localparam logic [63:0] TL_C = 64'h1357_9BDF_2468_ACE0;

    logic clk = 1'b0;
    logic rst_n;
    logic scl_m, sda_m, pwr_fail;
    logic [63:0] tl;
    logic sda_oe, tm_wr_en;
    logic [2:0] tm_wr_idx;
    logic [7:0] tm_wr_data;
    wire sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    rtcb_target uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .pwr_fail   (pwr_fail),
        .time_live  (tl),
        .tm_wr_en   (tm_wr_en),
        .tm_wr_idx  (tm_wr_idx),
        .tm_wr_data (tm_wr_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int tw_cnt  = 0;
    int oe_hits = 0;
    logic [7:0] tw_data [8];
    logic [7:0] exp_mem [64];
    logic [63:0] snap_exp;

    always @(posedge clk) begin
        if (tm_wr_en) begin
            tw_data[tm_wr_idx] <= tm_wr_data;
            tw_cnt <= tw_cnt + 1;
        end
        if (sda_oe) oe_hits <= oe_hits + 1;
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    function automatic logic [7:0] exp_at(input int a);
        if (a < 8) return snap_exp[a*8 +: 8];
        return exp_mem[a];
    endfunction

    // Write n bytes from address addr, data seed + 29*i; checks acks and time strobes.
    task automatic write_check(input int addr, input int n, input logic [7:0] seed, input string req);
        logic ack;
        int cnt0;
        int nt;
        cnt0 = tw_cnt;
        nt = 0;
        bus_start();
        write_byte(8'hD0, ack); chk({req, " addr ack"}, ack, 1);
        write_byte(8'(addr), ack); chk({req, " ptr ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            int a;
            logic [7:0] d;
            a = (addr + i) % 64;
            d = 8'(seed + 8'(29 * i));
            write_byte(d, ack); chk({req, " data ack"}, ack, 1);
            if (a >= 8) exp_mem[a] = d;
            else begin
                nt++;
                chk({req, " time strobe data"}, tw_data[a], d);
            end
        end
        bus_stop();
        chk({req, " time strobe count"}, 64'(tw_cnt - cnt0), 64'(nt));
    endtask

    // Read n bytes starting at addr (pointer written first when set_ptr).
    task automatic read_check(input bit set_ptr, input int addr, input int n,
                              input bit flip, input logic [63:0] tl_new, input string req);
        logic ack;
        logic [7:0] d;
        snap_exp = tl;
        bus_start();
        if (set_ptr) begin
            write_byte(8'hD0, ack); chk({req, " addr ack"}, ack, 1);
            write_byte(8'(addr), ack); chk({req, " ptr ack"}, ack, 1);
            bus_rstart();
        end
        write_byte(8'hD1, ack); chk({req, " read addr ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(d, i != n - 1);
            chk({req, " read data"}, d, exp_at((addr + i) % 64));
            if (flip && i == 0) tl = tl_new;
        end
        bus_stop();
    endtask

    // R9 coincidence: power fail rises with the SCL fall that completes a byte
    task automatic write_byte_pf(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 1; i--) send_bit(d[i]);
        sda_m = d[0]; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; pwr_fail = 1'b1; wq();
        recv_bit(b);
        ack = ~b;
        pwr_fail = 1'b0;
    endtask

    initial begin
        logic ack, ack2;
        logic [7:0] d;
        int h;
        int c0;
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; pwr_fail = 1'b0; tl = TL_A;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R7 reset tm_wr_en", tm_wr_en, 0);

        // R1: every 7-bit address, only 1101000 answers
        for (int a = 0; a < 128; a++) begin
            h = oe_hits;
            bus_start();
            write_byte({7'(a), 1'b0}, ack);
            write_byte(8'hFF, ack2);
            bus_stop();
            if (a == 7'h68) chk("R1 match ack", ack, 1);
            else begin
                chk("R1 mismatch ack", ack, 0);
                chk("R1 mismatch no drive", 64'(oe_hits - h), 0);
            end
        end

        // R4: full RAM sweep write
        write_check(8, 56, 8'h3B, "R4 ram burst");

        // R6 R8 R2: read 64 bytes from 8 across wrap, live time changes after first byte
        tl = TL_A;
        read_check(1, 8, 64, 1, TL_B, "R6 R8 R2 wrap read");

        // R5: retained pointer continues (pointer is 8 again after 64 reads)
        tl = TL_B;
        read_check(0, 8, 3, 0, TL_B, "R5 retained start");
        read_check(0, 11, 1, 0, TL_B, "R5 retained continue");

        // R7: time writes go to strobe, RAM after
        write_check(6, 3, 8'h59, "R7 time write");
        read_check(1, 6, 3, 0, TL_B, "R7 shadow unaffected");

        // R6: write wrap from 63 to 0
        write_check(63, 2, 8'hA5, "R6 write wrap");
        read_check(1, 63, 1, 0, TL_B, "R6 last ram byte");

        // R4: upper pointer bits ignored (0xCA -> 0x0A)
        bus_start();
        write_byte(8'hD0, ack);
        write_byte(8'hCA, ack); chk("R4 ptr ack", ack, 1);
        write_byte(8'h11, ack); chk("R4 data ack", ack, 1);
        bus_stop();
        exp_mem[10] = 8'h11;
        read_check(1, 10, 1, 0, TL_B, "R4 upper bits ignored");

        // R9: power fail mid write
        c0 = tw_cnt;
        bus_start();
        write_byte(8'hD0, ack);
        write_byte(8'h20, ack);
        write_byte(8'h55, ack); chk("R9 pre-fail ack", ack, 1);
        exp_mem[32] = 8'h55;
        pwr_fail = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 released", sda_oe, 0);
        write_byte(8'h66, ack); chk("R9 no ack during fail", ack, 0);
        pwr_fail = 1'b0;
        write_byte(8'h77, ack); chk("R9 still ignored after fail", ack, 0);
        bus_stop();
        read_check(0, 0, 1, 0, TL_B, "R9 pointer cleared");
        read_check(1, 32, 2, 0, TL_B, "R9 ram untouched");

        // R9: START not recognised while failing
        pwr_fail = 1'b1;
        bus_start();
        write_byte(8'hD0, ack); chk("R9 start ignored", ack, 0);
        bus_stop();
        pwr_fail = 1'b0;

        // R9: coincident commit and power fail, RAM and time locations
        bus_start();
        write_byte(8'hD0, ack);
        write_byte(8'h30, ack);
        write_byte_pf(8'hEE, ack); chk("R9 coincident ram ack", ack, 0);
        bus_stop();
        read_check(1, 48, 1, 0, TL_B, "R9 coincident ram kept");
        c0 = tw_cnt;
        bus_start();
        write_byte(8'hD0, ack);
        write_byte(8'h03, ack);
        write_byte_pf(8'h42, ack); chk("R9 coincident time ack", ack, 0);
        bus_stop();
        chk("R9 coincident no strobe", 64'(tw_cnt - c0), 0);

        // R8: fresh snapshot per START
        tl = TL_C;
        read_check(1, 0, 8, 0, TL_C, "R8 new snapshot");

        // R5: after NACK the line stays released
        snap_exp = tl;
        bus_start();
        write_byte(8'hD1, ack);
        read_byte(d, 1'b0);
        h = oe_hits;
        for (int i = 0; i < 9; i++) recv_bit(ack2);
        chk("R5 released after nack", 64'(oe_hits - h), 0);
        bus_stop();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule